// File: doc/BRIEF.md
# Slow Crystal Clock Frequency Monitor

This block checks that a nominally 32768 Hz slow clock runs at the right rate. It runs on a faster, trusted reference clock. The slow clock arrives asynchronously and passes through a synchronizer with rising-edge detection. The block counts reference cycles between consecutive slow-clock rising edges and compares each period against a tolerance window of plus or minus a configurable percentage (10 % by default) around the nominal count. The nominal count is a parameter, normally the reference frequency divided by 32768.

A single bad period is not enough to report a fault. Only a run of consecutive out-of-window measurements raises the error flag, which is four by default. Any good period breaks the run. A slow clock that stops entirely is caught by a timeout: if no edge arrives within a multiple of the upper bound, that interval counts as one failed measurement and timing restarts. Once raised, the error flag is sticky. Software can clear it only after disabling the monitor.

Top module: `xtal_freq_mon`

## Requirements
- R1: After reset `err_flag` is 0.
- R2: While `mon_en` is 0, no measurement is evaluated, the consecutive-failure run is held at zero, and `err_flag` never rises.
- R3: After `mon_en` rises, the partial slow-clock period up to the first synchronized rising edge is discarded, and measurement starts at that edge.
- R4: A measured period P (reference cycles between two consecutive slow-clock rising edges) is in window exactly when LO <= P <= HI, with LO = ceil(NOMINAL_CNT*(100-TOL_PCT)/100) and HI = floor(NOMINAL_CNT*(100+TOL_PCT)/100). A period within 1 % of nominal is therefore always in window, and a period deviating by more than TOL_PCT % is always out of window.
- R5: When FAIL_LIMIT consecutive measurements fall outside the window, `err_flag` is set no later than six reference cycles after the slow-clock rising edge that ends the last of them.
- R6: Any in-window measurement resets the consecutive-failure run to zero.
- R7: If TMO_MULT*HI reference cycles pass with no slow-clock rising edge while enabled, that interval counts as one failed measurement and the period counter restarts. A stopped slow clock therefore sets `err_flag` after about FAIL_LIMIT*TMO_MULT*HI cycles.
- R8: Once set, `err_flag` stays 1 while `mon_en` is 1. This holds for good periods and for `clr_err` pulses.
- R9: `clr_err` at 1 while `mon_en` is 0 clears `err_flag` on the next cycle. Dropping `mon_en` alone does not clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; all logic runs on it |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_en | input | 1 | Monitor enable |
| slow_clk | input | 1 | Asynchronous slow clock under test |
| clr_err | input | 1 | Error clear request; effective only while `mon_en` is 0 |
| err_flag | output | 1 | Sticky frequency error flag |

## Verification
The bench drives the window edges one count inside and one count outside: LO, HI, LO-1 and HI+1. It also drives periods 1 % off nominal. A design with an off-by-one period count or a floor/ceiling mix-up flags a good clock or misses a bad one.

The bench builds runs of three bad periods broken by a good one. A design that does not reset the run raises the flag too early.

In one case, monitoring starts just before a rising edge, followed by three bad periods. A design that measures the partial first period counts four failures and flags.

A stopped clock is observed on both sides of the fourth timeout. A missing or mis-sized timeout leaves the flag low or raises it early.

The clear rule is probed in two ways: with `clr_err` pulsed while enabled, and with the monitor merely disabled. A design that clears too eagerly loses the flag in either case.

// File: rtl/xfm_pkg.sv
package xfm_pkg;

   typedef enum logic [1:0] {
      MEAS_NONE = 2'b00,
      MEAS_PASS = 2'b01,
      MEAS_FAIL = 2'b10
   } meas_e;

   // lower window bound, rounded up so anything beyond tolerance is out
   function automatic int unsigned lo_bound(int unsigned nom, int unsigned tol);
      return (nom * (100 - tol) + 99) / 100;
   endfunction

   // upper window bound, rounded down for the same reason
   function automatic int unsigned hi_bound(int unsigned nom, int unsigned tol);
      return (nom * (100 + tol)) / 100;
   endfunction

endpackage

// File: rtl/xfm_sync_edge.sv
module xfm_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_o
);

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      if (STAGES == 1) begin : g_one_stage
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= async_in;
         end
      end else begin : g_multi_stage
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], async_in};
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain_q[STAGES-1];
   end

   assign rise_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/xfm_period_meter.sv
module xfm_period_meter
   import xfm_pkg::*;
#(
   parameter int unsigned CNT_W   = 10,
   parameter int unsigned LO_CNT  = 180,
   parameter int unsigned HI_CNT  = 220,
   parameter int unsigned TMO_CNT = 440
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             rise,
   output meas_e            meas_o,
   output logic [CNT_W-1:0] cnt_o
);

   localparam logic [CNT_W-1:0] LO_V  = CNT_W'(LO_CNT);
   localparam logic [CNT_W-1:0] HI_V  = CNT_W'(HI_CNT);
   localparam logic [CNT_W-1:0] TMO_V = CNT_W'(TMO_CNT);
   localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;
   meas_e            meas_q;
   logic             in_win;

   assign in_win = (cnt_q >= LO_V) && (cnt_q <= HI_V);

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
         meas_q  <= MEAS_NONE;
      end else begin
         meas_q <= MEAS_NONE;
         if (rise) begin
            cnt_q   <= ONE_V;
            armed_q <= 1'b1;
            if (armed_q) meas_q <= in_win ? MEAS_PASS : MEAS_FAIL;
         end else if (cnt_q == TMO_V) begin
            cnt_q  <= ONE_V;
            meas_q <= MEAS_FAIL;
         end else begin
            cnt_q <= cnt_q + ONE_V;
         end
      end
   end

   assign meas_o = meas_q;
   assign cnt_o  = cnt_q;

endmodule

// File: rtl/xfm_fail_tracker.sv
module xfm_fail_tracker
   import xfm_pkg::*;
#(
   parameter int unsigned FAIL_LIMIT = 4,
   parameter int unsigned RUN_W      = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             clr_req,
   input  meas_e            meas,
   output logic             err_o,
   output logic [RUN_W-1:0] run_o
);

   localparam logic [RUN_W-1:0] LIM_V  = RUN_W'(FAIL_LIMIT);
   localparam logic [RUN_W-1:0] LAST_V = RUN_W'(FAIL_LIMIT - 1);

   logic [RUN_W-1:0] run_q;
   logic             err_q;

   generate
      if (FAIL_LIMIT == 1) begin : g_single
         always_ff @(posedge clk) begin
            run_q <= '0;
            if (!rst_n) begin
               err_q <= 1'b0;
            end else if (!en) begin
               if (clr_req) err_q <= 1'b0;
            end else if (meas == MEAS_FAIL) begin
               err_q <= 1'b1;
            end
         end
      end else begin : g_counted
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               run_q <= '0;
               err_q <= 1'b0;
            end else if (!en) begin
               run_q <= '0;
               if (clr_req) err_q <= 1'b0;
            end else begin
               case (meas)
                  MEAS_PASS: run_q <= '0;
                  MEAS_FAIL: begin
                     if (run_q >= LAST_V) err_q <= 1'b1;
                     if (run_q != LIM_V)  run_q <= run_q + RUN_W'(1);
                  end
                  default: ;
               endcase
            end
         end
      end
   endgenerate

   assign err_o = err_q;
   assign run_o = run_q;

endmodule

// File: rtl/xtal_freq_mon.sv
module xtal_freq_mon
   import xfm_pkg::*;
#(
   parameter int unsigned NOMINAL_CNT = 1000,
   parameter int unsigned TOL_PCT     = 10,
   parameter int unsigned FAIL_LIMIT  = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TMO_MULT    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mon_en,
   input  logic slow_clk,
   input  logic clr_err,
   output logic err_flag
);

   localparam int unsigned LO_CNT  = lo_bound(NOMINAL_CNT, TOL_PCT);
   localparam int unsigned HI_CNT  = hi_bound(NOMINAL_CNT, TOL_PCT);
   localparam int unsigned TMO_CNT = TMO_MULT * HI_CNT;
   localparam int unsigned CNT_W   = $clog2(TMO_CNT + 1);
   localparam int unsigned RUN_W   = $clog2(FAIL_LIMIT + 1);

   generate
      if (TOL_PCT < 1 || TOL_PCT > 99) begin : g_bad_tol
         initial $fatal(1, "xtal_freq_mon: TOL_PCT must lie in 1..99");
      end
      if (NOMINAL_CNT < 10) begin : g_bad_nom
         initial $fatal(1, "xtal_freq_mon: NOMINAL_CNT too small for synchronizer latency");
      end
      if (FAIL_LIMIT < 1) begin : g_bad_lim
         initial $fatal(1, "xtal_freq_mon: FAIL_LIMIT must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         initial $fatal(1, "xtal_freq_mon: SYNC_STAGES must be at least 1");
      end
      if (TMO_MULT < 2) begin : g_bad_tmo
         initial $fatal(1, "xtal_freq_mon: TMO_MULT must be at least 2");
      end
   endgenerate

   logic             rise_s;
   meas_e            meas_s;
   logic [CNT_W-1:0] period_cnt_s;
   logic [RUN_W-1:0] fail_run_s;

   xfm_sync_edge #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (slow_clk),
      .rise_o   (rise_s)
   );

   xfm_period_meter #(
      .CNT_W   (CNT_W),
      .LO_CNT  (LO_CNT),
      .HI_CNT  (HI_CNT),
      .TMO_CNT (TMO_CNT)
   ) u_meter (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (mon_en),
      .rise   (rise_s),
      .meas_o (meas_s),
      .cnt_o  (period_cnt_s)
   );

   xfm_fail_tracker #(
      .FAIL_LIMIT (FAIL_LIMIT),
      .RUN_W      (RUN_W)
   ) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (mon_en),
      .clr_req (clr_err),
      .meas    (meas_s),
      .err_o   (err_flag),
      .run_o   (fail_run_s)
   );

endmodule

// File: rtl/xfm_checker.sv
module xfm_checker
   import xfm_pkg::*;
#(
   parameter int unsigned FAIL_LIMIT = 4,
   parameter int unsigned CNT_W      = 10,
   parameter int unsigned RUN_W      = 3,
   parameter int unsigned TMO_CNT    = 440
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mon_en,
   input logic             clr_err,
   input logic             err_flag,
   input meas_e            meas,
   input logic [CNT_W-1:0] period_cnt,
   input logic [RUN_W-1:0] fail_run
);

   // R2: disabled monitor produces no measurement and holds the run at zero
   p_idle_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !mon_en |=> (meas == MEAS_NONE && fail_run == '0));

   // R2: the flag only rises as a result of an enabled cycle
   p_no_rise_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> $past(mon_en));

   // R5: the flag rises only on a failure that completes the run
   p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> $past(meas == MEAS_FAIL && fail_run >= RUN_W'(FAIL_LIMIT - 1)));

   // R5: run counter saturates at the limit
   p_run_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fail_run <= RUN_W'(FAIL_LIMIT));

   // R6: a passing measurement clears the run
   p_pass_resets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_en && meas == MEAS_PASS) |=> fail_run == '0);

   // R7: the period counter never passes the timeout
   p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      period_cnt <= CNT_W'(TMO_CNT));

   // R7: at the timeout the counter restarts
   p_tmo_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_en && period_cnt == CNT_W'(TMO_CNT)) |=> period_cnt == CNT_W'(1));

   // R8: the flag holds unless a clear arrives while disabled
   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && (mon_en || !clr_err)) |=> err_flag);

   // R9: a clear while disabled takes effect
   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!mon_en && clr_err) |=> !err_flag);

endmodule

bind xtal_freq_mon xfm_checker #(
   .FAIL_LIMIT (FAIL_LIMIT),
   .CNT_W      (CNT_W),
   .RUN_W      (RUN_W),
   .TMO_CNT    (TMO_CNT)
) u_xfm_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mon_en     (mon_en),
   .clr_err    (clr_err),
   .err_flag   (err_flag),
   .meas       (meas_s),
   .period_cnt (period_cnt_s),
   .fail_run   (fail_run_s)
);

// File: tb/xtal_freq_mon_tb_top.sv
`timescale 1ns/1ps
module xtal_freq_mon_tb_top;

   localparam int NOM   = 200;
   localparam int TOL   = 10;
   localparam int LIMIT = 4;
   localparam int LO    = (NOM * (100 - TOL) + 99) / 100;  // 180
   localparam int HI    = (NOM * (100 + TOL)) / 100;       // 220
   localparam int TMO   = 2 * HI;                          // 440
   localparam int WATCHDOG = 190000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mon_en = 1'b0;
   logic slow_clk = 1'b0;
   logic clr_err = 1'b0;
   logic err_flag;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   // bench model state
   bit m_en = 0;
   bit m_err = 0;
   int m_run = 0;
   bit m_pend = 0;
   int m_prev = 0;

   always #2 clk = ~clk;

   xtal_freq_mon #(
      .NOMINAL_CNT (NOM),
      .TOL_PCT     (TOL),
      .FAIL_LIMIT  (LIMIT),
      .SYNC_STAGES (2),
      .TMO_MULT    (2)
   ) dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .mon_en   (mon_en),
      .slow_clk (slow_clk),
      .clr_err  (clr_err),
      .err_flag (err_flag)
   );

   function automatic bit in_window(int p);
      return (p >= LO) && (p <= HI);
   endfunction

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(bit act, bit exp, string req, string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: err_flag actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   task automatic model_edge();
      if (m_en) begin
         if (m_pend) begin
            if (in_window(m_prev)) m_run = 0;
            else begin
               m_run++;
               if (m_run >= LIMIT) m_err = 1;
            end
         end
      end
   endtask

   // one slow period of p reference cycles; rising edge at start
   task automatic slow_period(int p, string req, int probe = 0, bit clr_mid = 0);
      model_edge();
      if (m_en) begin m_pend = 1; m_prev = p; end
      slow_clk = 1'b1;
      if (probe > 0) begin
         tick(probe);
         check(err_flag, m_err, req, $sformatf("probe %0d after edge", probe));
         tick(p / 2 - probe);
      end else begin
         tick(p / 2);
      end
      slow_clk = 1'b0;
      if (clr_mid) begin
         clr_err = 1'b1; tick(1); clr_err = 1'b0;
         tick(p - p / 2 - 1);
      end else begin
         tick(p - p / 2);
      end
      check(err_flag, m_err, req, $sformatf("after period %0d", p));
   endtask

   task automatic set_en(bit v);
      mon_en = v;
      m_en = v;
      m_pend = 0;
      m_run = 0;
      tick(1);
   endtask

   task automatic disable_clear();
      set_en(0);
      tick(2);
      clr_err = 1'b1; tick(1); clr_err = 1'b0;
      m_err = 0;
      tick(2);
   endtask

   initial begin : watchdog
      tick(WATCHDOG);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd4051));
      tick(5);
      rst_n = 1'b1;
      tick(2);
      check(err_flag, 1'b0, "R1", "after reset");

      // R2: bad clock while disabled never flags
      for (int i = 0; i < 6; i++) slow_period(50, "R2");

      // R4: window edges, 1% points, then four outside
      set_en(1);
      slow_period(NOM, "R4");
      slow_period(LO, "R4"); slow_period(HI, "R4");
      slow_period(LO, "R4"); slow_period(HI, "R4");
      slow_period(NOM - 2, "R4"); slow_period(NOM + 2, "R4");
      slow_period(LO - 1, "R4"); slow_period(HI + 1, "R4"); slow_period(LO - 1, "R4");
      slow_period(NOM, "R4");
      slow_period(HI + 1, "R4"); slow_period(LO - 1, "R4");
      slow_period(HI + 1, "R4"); slow_period(LO - 1, "R4");
      // R5: flag within six cycles of the edge closing the fourth failure
      slow_period(NOM, "R5", 6);
      check(err_flag, 1'b1, "R5", "four consecutive failures");

      // R8: clear while enabled ignored, good periods keep it
      slow_period(NOM, "R8", 0, 1);
      slow_period(NOM, "R8", 0, 1);
      check(err_flag, 1'b1, "R8", "sticky while enabled");

      // R9: disable alone keeps flag, clear while disabled drops it
      set_en(0);
      tick(10);
      check(err_flag, 1'b1, "R9", "disable alone");
      clr_err = 1'b1; tick(1); clr_err = 1'b0;
      tick(1);
      check(err_flag, 1'b0, "R9", "clear while disabled");
      m_err = 0;

      // R6: a good period breaks the run
      set_en(1);
      slow_period(NOM, "R6");
      for (int i = 0; i < 3; i++) slow_period(60, "R6");
      slow_period(NOM, "R6");
      for (int i = 0; i < 3; i++) slow_period(HI + 30, "R6");
      slow_period(NOM, "R6");
      slow_period(NOM, "R6");
      check(err_flag, 1'b0, "R6", "broken runs");

      // R3: partial first period discarded
      disable_clear();
      tick(30);
      mon_en = 1'b1; m_en = 1; m_pend = 0; m_run = 0;
      tick(3);
      for (int i = 0; i < 3; i++) slow_period(100, "R3");
      slow_period(NOM, "R3");
      slow_period(NOM, "R3");
      check(err_flag, 1'b0, "R3", "partial period not counted");

      // R7: stopped clock
      disable_clear();
      set_en(1);
      tick(LIMIT * TMO - 12);
      check(err_flag, 1'b0, "R7", "before fourth timeout");
      tick(30);
      check(err_flag, 1'b1, "R7", "after fourth timeout");
      disable_clear();

      // random mix: R4 R5 R6 R8
      set_en(1);
      for (int i = 0; i < 320; i++) begin
         int cls;
         int p;
         cls = $urandom_range(0, 9);
         if (cls < 5)      p = $urandom_range(LO, HI);
         else if (cls < 8) p = $urandom_range(20, LO - 1);
         else              p = $urandom_range(HI + 1, TMO - 1);
         slow_period(p, "R5", 0, ($urandom_range(0, 7) == 0));
         if ((i % 30) == 29) begin
            disable_clear();
            check(err_flag, 1'b0, "R9", "random clear");
            set_en(1);
         end
      end

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule